// File: doc/BRIEF.md
# Deterministic-Latency Comma Word Aligner

This block sits behind a deserializer and restores 10-bit symbol boundaries in a stream of raw parallel words. The words are either one symbol wide (narrow mode) or two symbols wide (wide mode). After reset it searches on its own for the K28.5 comma. When it finds the comma it locks onto that bit offset and reports the offset as a boundary value. Downstream logic can use that value to compensate latency elsewhere in the link.

From then on every output word is re-framed so that the comma sits in the low symbol. The input-to-output delay is a fixed three cycles. In automatic mode the block also raises a clock-slip request for one cycle per bit of offset, which asks the serial side to absorb the slip. In manual mode it only reports the offset.

Once locked, the block ignores commas at other offsets. It re-aligns only when software-side logic raises a re-alignment request, and only while that request is safe to act on.

Top module: `comma_word_aligner`

## Requirements
- R1: While rst_ni is low, data_o, sync_o, boundary_o and slip_o are all zero. After reset releases, the comma search runs without any request.
- R2: The search pattern is the 10-bit value 0011111010 (bit 0 is the rightmost digit). The search window is {current word, previous word} of the last two captured words. A match at offset k means window[k+9:k] equals the pattern.
- R3: In wide mode (wide_i=1) the search uses all 20 bits of data_i and offsets 0 to 19. In narrow mode it uses data_i[9:0] and offsets 0 to 9. When several offsets match, the lowest one wins.
- R4: boundary_o takes the winning offset on the edge after the window that matched. It holds that value until the next alignment.
- R5: data_o is the window shifted right by the active boundary, cut to the mode width, with bits 19:10 at zero in narrow mode. A word sampled at edge n reaches data_o after edge n+2. The matching comma lands in data_o[9:0].
- R6: sync_o rises one cycle after the aligned comma first appears on data_o. It stays high until a re-alignment request is accepted.
- R7: With manual_i=0, slip_o is high for exactly boundary_o consecutive cycles, starting right after the boundary update. With manual_i=1, slip_o stays low.
- R8: While locked, a comma at any offset leaves boundary_o unchanged.
- R9: realign_i is accepted only when slip_o is low and either sync_o is high or boundary_o changed from non-zero to 0 or 1 on the previous edge. Otherwise it is ignored. Acceptance clears sync_o.
- R10: After an accepted request, the search resumes. Output framing keeps the old boundary until a new comma is found, and that new offset then becomes boundary_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: two-symbol words, 0: one-symbol words |
| manual_i | input | 1 | 1: report offset only, no slip requests |
| realign_i | input | 1 | Re-alignment request |
| data_i | input | 20 | Raw deserialized word |
| data_o | output | 20 | Re-framed word |
| sync_o | output | 1 | Alignment reached the output |
| boundary_o | output | 5 | Latched bit offset of the comma |
| slip_o | output | 1 | Clock-slip request, one cycle per slipped bit |

## Verification
A wrong search or priority shows up as a wrong boundary_o on the edge after the comma window. Three cycles after the comma enters, a wrong re-framing shows up as a misplaced comma on data_o. A corrupted slip counter changes the length of the slip_o burst, and a faulty acceptance gate shows up either as sync_o dropping when it should hold or as boundary_o moving after a comma the block should have ignored. A reference model checks every output on every cycle, so any such fault is caught within one cycle of its first effect at the ports.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int unsigned SYM_W = 10;
  localparam int unsigned LANES = 2;
  localparam logic [SYM_W-1:0] COMMA_K = 10'b0011111010;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } cwa_state_e;
endpackage

// File: rtl/cwa_finder.sv
module cwa_finder #(
  parameter int unsigned SYM_W = cwa_pkg::SYM_W,
  parameter int unsigned LANES = cwa_pkg::LANES,
  parameter logic [SYM_W-1:0] PATTERN = cwa_pkg::COMMA_K,
  localparam int unsigned DW    = SYM_W * LANES,
  localparam int unsigned WIN_W = 2 * DW,
  localparam int unsigned OFF_W = $clog2(DW)
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic             wide_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] off_o
);
  logic [DW-1:0] match;

  for (genvar k = 0; k < DW; k++) begin : g_cmp
    if (k < SYM_W) begin : g_any
      assign match[k] = (win_i[k +: SYM_W] == PATTERN);
    end else begin : g_wide
      assign match[k] = wide_i && (win_i[k +: SYM_W] == PATTERN);
    end
  end

  // lowest offset wins
  always_comb begin
    off_o = '0;
    for (int k = DW - 1; k >= 0; k--) begin
      if (match[k]) off_o = OFF_W'(k);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/cwa_shifter.sv
module cwa_shifter #(
  parameter int unsigned SYM_W = cwa_pkg::SYM_W,
  parameter int unsigned LANES = cwa_pkg::LANES,
  localparam int unsigned DW    = SYM_W * LANES,
  localparam int unsigned WIN_W = 2 * DW,
  localparam int unsigned OFF_W = $clog2(DW)
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] sel_i,
  input  logic             wide_i,
  output logic [DW-1:0]    data_o
);
  logic [WIN_W-1:0] shifted;
  logic [DW-1:0]    keep;

  assign shifted = win_i >> sel_i;

  always_comb begin
    keep = '0;
    keep[SYM_W-1:0] = '1;
    if (wide_i) keep = '1;
  end

  assign data_o = shifted[DW-1:0] & keep;
endmodule

// File: rtl/cwa_ctrl.sv
module cwa_ctrl #(
  parameter int unsigned SYM_W = cwa_pkg::SYM_W,
  parameter int unsigned LANES = cwa_pkg::LANES,
  localparam int unsigned DW    = SYM_W * LANES,
  localparam int unsigned OFF_W = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             manual_i,
  input  logic             realign_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             out_hit_i,
  output logic             take_o,
  output logic [OFF_W-1:0] boundary_o,
  output logic             slip_o,
  output logic             sync_o
);
  import cwa_pkg::*;

  cwa_state_e       state_q;
  logic [OFF_W-1:0] slip_cnt_q;
  logic             fell_q;
  logic             accept;

  assign take_o = (state_q == ST_SEARCH) && hit_i;
  assign slip_o = (slip_cnt_q != '0);
  // safe points for a new alignment
  assign accept = (state_q == ST_LOCKED) && realign_i && !slip_o && (sync_o || fell_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SEARCH;
      boundary_o <= '0;
      slip_cnt_q <= '0;
      fell_q     <= 1'b0;
      sync_o     <= 1'b0;
    end else begin
      fell_q <= 1'b0;
      if (slip_o) slip_cnt_q <= slip_cnt_q - 1'b1;
      if (take_o) begin
        boundary_o <= off_i;
        slip_cnt_q <= manual_i ? '0 : off_i;
        fell_q     <= (boundary_o != '0) && (off_i <= OFF_W'(1));
        state_q    <= ST_LOCKED;
      end
      if (accept) begin
        state_q <= ST_SEARCH;
        sync_o  <= 1'b0;
      end else if (out_hit_i && state_q == ST_LOCKED) begin
        sync_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int unsigned SYM_W = cwa_pkg::SYM_W,
  parameter int unsigned LANES = cwa_pkg::LANES,
  parameter logic [SYM_W-1:0] PATTERN = cwa_pkg::COMMA_K,
  localparam int unsigned DW    = SYM_W * LANES,
  localparam int unsigned WIN_W = 2 * DW,
  localparam int unsigned OFF_W = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             manual_i,
  input  logic             realign_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             sync_o,
  output logic [OFF_W-1:0] boundary_o,
  output logic             slip_o
);
  logic [DW-1:0]    cur_q, prev_q, ext_q;
  logic             ext_hit_q, out_hit_q;
  logic [WIN_W-1:0] win;
  logic             hit, take;
  logic [OFF_W-1:0] off, sel;
  logic [DW-1:0]    framed;

  always_comb begin
    win = '0;
    win[2*SYM_W-1:0] = {cur_q[SYM_W-1:0], prev_q[SYM_W-1:0]};
    if (wide_i) win = {cur_q, prev_q};
  end

  cwa_finder #(.SYM_W(SYM_W), .LANES(LANES), .PATTERN(PATTERN)) i_finder (
    .win_i  (win),
    .wide_i (wide_i),
    .hit_o  (hit),
    .off_o  (off)
  );

  assign sel = take ? off : boundary_o;

  cwa_shifter #(.SYM_W(SYM_W), .LANES(LANES)) i_shifter (
    .win_i  (win),
    .sel_i  (sel),
    .wide_i (wide_i),
    .data_o (framed)
  );

  cwa_ctrl #(.SYM_W(SYM_W), .LANES(LANES)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .manual_i   (manual_i),
    .realign_i  (realign_i),
    .hit_i      (hit),
    .off_i      (off),
    .out_hit_i  (out_hit_q),
    .take_o     (take),
    .boundary_o (boundary_o),
    .slip_o     (slip_o),
    .sync_o     (sync_o)
  );

  // three register stages: capture, frame, output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      prev_q    <= '0;
      ext_q     <= '0;
      ext_hit_q <= 1'b0;
      data_o    <= '0;
      out_hit_q <= 1'b0;
    end else begin
      cur_q     <= data_i;
      prev_q    <= cur_q;
      ext_q     <= framed;
      ext_hit_q <= take;
      data_o    <= ext_q;
      out_hit_q <= ext_hit_q;
    end
  end
endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int unsigned SYM_W = cwa_pkg::SYM_W,
  parameter int unsigned LANES = cwa_pkg::LANES,
  parameter logic [SYM_W-1:0] PATTERN = cwa_pkg::COMMA_K,
  localparam int unsigned DW    = SYM_W * LANES,
  localparam int unsigned OFF_W = $clog2(DW)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wide_i,
  input logic             manual_i,
  input logic             realign_i,
  input logic [DW-1:0]    data_o,
  input logic             sync_o,
  input logic [OFF_W-1:0] boundary_o,
  input logic             slip_o
);
  p_bnd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(boundary_o) < (wide_i ? DW : SYM_W));

  p_bnd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(boundary_o) |-> !$past(sync_o));

  p_sync_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(data_o[SYM_W-1:0]) == PATTERN);

  p_no_manual_slip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> !manual_i);

  p_accept_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i && sync_o && !slip_o |=> !sync_o);

  p_slip_not_synced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_o) |-> !$past(sync_o));
endmodule

bind comma_word_aligner cwa_checker #(.SYM_W(SYM_W), .LANES(LANES), .PATTERN(PATTERN)) i_cwa_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wide_i     (wide_i),
  .manual_i   (manual_i),
  .realign_i  (realign_i),
  .data_o     (data_o),
  .sync_o     (sync_o),
  .boundary_o (boundary_o),
  .slip_o     (slip_o)
);

// File: tb/test_comma_word_aligner.sv
`timescale 1ns/1ps
module test_comma_word_aligner;
  localparam logic [9:0]  COMMA = 10'b0011111010;
  localparam logic [19:0] FILL  = 20'h55555;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b1, manual_i = 1'b0, realign_i = 1'b0;
  logic [19:0] data_i = FILL;
  logic [19:0] data_o;
  logic        sync_o, slip_o;
  logic [4:0]  boundary_o;

  int checks = 0, errors = 0, slip_seen = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  comma_word_aligner i_comma_word_aligner (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .manual_i(manual_i),
    .realign_i(realign_i), .data_i(data_i), .data_o(data_o), .sync_o(sync_o),
    .boundary_o(boundary_o), .slip_o(slip_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  function automatic logic [39:0] mk_win(logic [19:0] c, logic [19:0] p, logic w);
    return w ? {c, p} : {20'b0, c[9:0], p[9:0]};
  endfunction

  function automatic int find(logic [39:0] win, logic w);
    int lim = w ? 20 : 10;
    for (int k = 0; k < lim; k++) if (win[k +: 10] == COMMA) return k;
    return -1;
  endfunction

  function automatic logic [19:0] frame(logic [39:0] win, int sel, logic w);
    logic [19:0] r = '0;
    int lim = w ? 20 : 10;
    for (int i = 0; i < lim; i++) r[i] = win[sel + i];
    return r;
  endfunction

  logic [19:0] m_cur, m_prev, m_ext, m_out;
  bit m_search, m_ext_hit, m_out_hit, m_sync, m_fell;
  int m_bnd, m_cnt;
  logic [39:0] t_win;
  int t_off, t_sel;
  bit t_take, t_acc;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cur = 0; m_prev = 0; m_ext = 0; m_out = 0;
      m_search = 1; m_ext_hit = 0; m_out_hit = 0; m_sync = 0; m_fell = 0;
      m_bnd = 0; m_cnt = 0;
    end else begin
      t_win  = mk_win(m_cur, m_prev, wide_i);
      t_off  = find(t_win, wide_i);
      t_take = m_search && (t_off >= 0);
      t_acc  = !m_search && realign_i && (m_cnt == 0) && (m_sync || m_fell);
      t_sel  = t_take ? t_off : m_bnd;
      if (t_acc) m_sync = 0;
      else if (m_out_hit && !m_search) m_sync = 1;
      m_out = m_ext; m_out_hit = m_ext_hit;
      m_ext = frame(t_win, t_sel, wide_i); m_ext_hit = t_take;
      m_prev = m_cur; m_cur = data_i;
      if (t_take) begin
        m_fell = (m_bnd != 0) && (t_off <= 1);
        m_bnd = t_off; m_cnt = manual_i ? 0 : t_off; m_search = 0;
      end else begin
        m_fell = 0;
        if (m_cnt > 0) m_cnt--;
      end
      if (t_acc) m_search = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(data_o == m_out, "R5 data_o", data_o, m_out);
      chk(sync_o == m_sync, "R6 sync_o", sync_o, m_sync);
      chk(boundary_o == m_bnd, "R4 boundary_o", boundary_o, m_bnd);
      chk(slip_o == (m_cnt != 0), "R7 slip_o", slip_o, m_cnt != 0);
    end
    if (slip_o) slip_seen++;
  end

  task automatic put(input logic [19:0] w);
    data_i = w;
    @(negedge clk_i);
  endtask

  task automatic pulse_realign();
    realign_i = 1;
    put(FILL);
    realign_i = 0;
  endtask

  task automatic do_reset(input logic w, input logic m);
    rst_ni = 0; wide_i = w; manual_i = m; realign_i = 0; data_i = FILL;
    repeat (2) @(negedge clk_i);
    chk(data_o == 0 && sync_o == 0 && boundary_o == 0 && slip_o == 0, "R1 reset outputs",
        {sync_o, slip_o, boundary_o}, 0);
    rst_ni = 1;
    repeat (3) put(FILL);
  endtask

  // places the comma at window offset k across two words
  task automatic inject(input int k);
    logic [39:0] s;
    s = {FILL, FILL};
    if (wide_i) begin
      s[k +: 10] = COMMA;
      put(s[19:0]);
      put(s[39:20]);
    end else begin
      s[19:0] = {FILL[9:0], FILL[9:0]};
      s[k +: 10] = COMMA;
      put({FILL[19:10], s[9:0]});
      put({FILL[19:10], s[19:10]});
    end
  endtask

  task automatic align_case(input logic w, input logic m, input int k);
    do_reset(w, m);
    slip_seen = 0;
    inject(k);
    put(FILL); put(FILL);
    chk(data_o[9:0] == COMMA, "R5 comma in low symbol after 3 cycles", data_o[9:0], COMMA);
    put(FILL);
    chk(sync_o == 1, "R6 sync after aligned comma", sync_o, 1);
    chk(boundary_o == k, "R3 lowest offset latched", boundary_o, k);
    repeat (22) put(FILL);
    chk(slip_seen == (m ? 0 : k), "R7 slip cycle count", slip_seen, m ? 0 : k);
  endtask

  initial begin
    @(negedge clk_i);
    // R1 R2 R3 R4 R5 R6 R7 sweeps over every offset
    for (int k = 0; k < 20; k++) align_case(1, 0, k);
    for (int k = 0; k < 10; k++) align_case(0, 1, k);
    for (int k = 0; k < 10; k += 3) align_case(0, 0, k);
    for (int k = 1; k < 20; k += 6) align_case(1, 1, k);

    // R8: locked aligner ignores a comma at another offset
    align_case(1, 0, 4);
    inject(11);
    repeat (4) put(FILL);
    chk(boundary_o == 4, "R8 locked boundary held", boundary_o, 4);
    chk(sync_o == 1, "R8 sync held", sync_o, 1);

    // R9: request while slipping is ignored, then accepted once idle
    do_reset(1, 0);
    inject(15);
    repeat (4) put(FILL);
    chk(slip_o == 1 && sync_o == 1, "R9 busy with sync", {slip_o, sync_o}, 2'b11);
    pulse_realign();
    chk(sync_o == 1, "R9 request during slip ignored", sync_o, 1);
    inject(2);
    repeat (4) put(FILL);
    chk(boundary_o == 15, "R9 boundary unchanged after ignored request", boundary_o, 15);
    repeat (15) put(FILL);
    pulse_realign();
    chk(sync_o == 0, "R9 accepted request clears sync", sync_o, 0);
    // R10: old framing until the new comma arrives
    repeat (3) put(FILL);
    chk(boundary_o == 15, "R10 boundary kept while searching", boundary_o, 15);
    inject(2);
    repeat (4) put(FILL);
    chk(boundary_o == 2, "R10 new offset after search", boundary_o, 2);
    chk(sync_o == 1, "R10 sync after new lock", sync_o, 1);

    // R9: falling-boundary window accepts a request without sync
    do_reset(1, 1);
    inject(9);
    repeat (4) put(FILL);
    pulse_realign();
    inject(1);
    put(FILL);
    pulse_realign();
    inject(6);
    repeat (4) put(FILL);
    chk(boundary_o == 6, "R9 request right after fall to 1 accepted", boundary_o, 6);

    // R9: same request one cycle late is ignored
    pulse_realign();
    inject(1);
    put(FILL); put(FILL);
    pulse_realign();
    inject(6);
    repeat (4) put(FILL);
    chk(boundary_o == 1, "R9 late request ignored", boundary_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule